// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block connects a simple synchronous request bus inside the chip to an external asynchronous static RAM of 262,144 words of 16 bits. A requester presents an address, write data, a two-bit lane mask and a read/write flag with a valid strobe. The controller then sequences the memory's active-low control pins: chip select, write strobe, output enable and one enable for each byte lane. It returns a single-cycle ready pulse, and on reads it also returns the captured word.

The memory is asynchronous, so the controller paces each access with a fixed number of wait cycles. That number is computed at elaboration from the memory access time and the clock period. The data bus is split into an outgoing word, an output-enable and an incoming word, so the pad ring or a behavioural model can resolve the bidirectional pins. The controller drives the bus only while the write strobe is low.

Top module: `sram_lane_ctl`

## Requirements
- R1: After reset and whenever no transaction is in progress, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n and mem_lb_n are all 1, mem_dq_oe is 0 and req_ready is 0.
- R2: A write accepted at clock edge k has the following cycles after edge k. Cycle 1 is setup: mem_ce_n=0, mem_we_n=1, mem_dq_oe=0. Cycles 2 to W+1 are the strobe: mem_we_n=0, mem_dq_oe=1 and mem_dq_out equal to the write data. Cycle W+2 is hold: mem_ce_n=0, mem_we_n=1, mem_dq_oe=0, req_ready=1. The address and lane enables do not change from setup through hold.
- R3: Lane mask bit 0 selects the lower lane (data bits 7:0) by driving mem_lb_n=0. Mask bit 1 selects the upper lane (bits 15:8) by driving mem_ub_n=0. A write changes only the selected lanes of the stored word.
- R4: A read accepted at edge k has the following cycles after edge k. Cycle 1 is setup: mem_ce_n=0, mem_oe_n=1, mem_we_n=1. Cycles 2 to W+1 are access: mem_oe_n=0. The data is captured at the edge that ends the last access cycle. In cycle W+2 all control pins are high, req_ready=1 and rsp_rdata holds the captured word.
- R5: In rsp_rdata, each lane the mask did not select reads as 0x00.
- R6: mem_dq_oe is 1 only while mem_we_n is 0. mem_oe_n and mem_we_n are never low together. In the cycle before mem_oe_n falls, mem_dq_oe is 0.
- R7: A request with mask 00 asserts no memory control pin, and req_ready is 1 in the cycle right after acceptance.
- R8: req_ready is high for exactly one cycle per transaction. Requests are accepted only while idle, so request inputs that change during a transaction do not affect it, and the cycle after ready is idle.
- R9: W equals ceil(ACCESS_NS / CLK_NS), with a minimum of 1.
- R10: While mem_ce_n is 0, mem_addr equals the address of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 1 upper, bit 0 lower |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read word |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | 16 | Word driven to the data pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 16 | Word sampled from the data pins |

## Verification
The bench writes and reads full words, single lower lanes and single upper lanes. Lane-isolation faults show up as a read-back that mixes in old or foreign bytes. Empty-mask requests separate a true no-operation from one that still pulses a strobe or alters memory. The lowest and highest addresses exercise every address line. Request fields are scrambled in the middle of each transaction, which exposes a controller that re-samples its inputs while busy. An access time spanning three clock periods shows whether the strobe length follows the computed wait count.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RSET,
    ST_RACC,
    ST_REND,
    ST_NOP
  } ctl_st_t;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic ub_n;
    logic lb_n;
    logic dq_oe;
    logic ready;
  } pin_t;

  localparam pin_t PIN_IDLE = pin_t'(7'b1111100);

  function automatic int wait_cycles(input int acc_ns, input int clk_ns);
    int w;
    w = (acc_ns + clk_ns - 1) / clk_ns;
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int WAITS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (WAITS < 2) ? 1 : $clog2(WAITS);
  localparam logic [CW-1:0] START = CW'(WAITS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= START;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_lane_pkg::*;
(
  input  ctl_st_t    st,
  input  logic [1:0] mask,
  output pin_t       pins
);
  always_comb begin
    pins = PIN_IDLE;
    unique case (st)
      ST_WSET, ST_RSET: begin
        pins.ce_n = 1'b0;
        pins.ub_n = ~mask[1];
        pins.lb_n = ~mask[0];
      end
      ST_WPUL: begin
        pins.ce_n  = 1'b0;
        pins.we_n  = 1'b0;
        pins.dq_oe = 1'b1;
        pins.ub_n  = ~mask[1];
        pins.lb_n  = ~mask[0];
      end
      ST_WHLD: begin
        pins.ce_n  = 1'b0;
        pins.ub_n  = ~mask[1];
        pins.lb_n  = ~mask[0];
        pins.ready = 1'b1;
      end
      ST_RACC: begin
        pins.ce_n = 1'b0;
        pins.oe_n = 1'b0;
        pins.ub_n = ~mask[1];
        pins.lb_n = ~mask[0];
      end
      ST_REND, ST_NOP: begin
        pins.ready = 1'b1;
      end
      default: pins = PIN_IDLE;
    endcase
  end
endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic [LANES-1:0]   mask,
  input  logic [LANES*8-1:0] dq_in,
  output logic [LANES*8-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[g*8 +: 8] <= 8'h00;
      end else if (capture) begin
        rdata[g*8 +: 8] <= mask[g] ? dq_in[g*8 +: 8] : 8'h00;
      end
    end
  end
endmodule

// File: rtl/sram_lane_ctl.sv
module sram_lane_ctl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int ACCESS_NS = 12,
  parameter int CLK_NS    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              req_ready,
  output logic [15:0]       rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int WAITS = wait_cycles(ACCESS_NS, CLK_NS);
  localparam int LANES = 2;

  ctl_st_t           st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic [1:0]        mask_q, mask_d;
  logic              accept, expired, t_load, t_run;
  pin_t              pin_d, pin_q;

  assign accept = (st_q == ST_IDLE) && req_valid;
  assign mask_d = accept ? req_mask : mask_q;
  assign t_load = (st_q == ST_WSET) || (st_q == ST_RSET);
  assign t_run  = (st_q == ST_WPUL) || (st_q == ST_RACC);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        if (req_mask == 2'b00)  st_d = ST_NOP;
        else if (req_write)     st_d = ST_WSET;
        else                    st_d = ST_RSET;
      end
      ST_WSET: st_d = ST_WPUL;
      ST_WPUL: if (expired) st_d = ST_WHLD;
      ST_WHLD: st_d = ST_IDLE;
      ST_RSET: st_d = ST_RACC;
      ST_RACC: if (expired) st_d = ST_REND;
      ST_REND: st_d = ST_IDLE;
      ST_NOP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      pin_q   <= PIN_IDLE;
    end else begin
      st_q   <= st_d;
      mask_q <= mask_d;
      pin_q  <= pin_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  sram_wait_timer #(.WAITS(WAITS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .run     (t_run),
    .expired (expired)
  );

  sram_pin_decode u_decode (
    .st   (st_d),
    .mask (mask_d),
    .pins (pin_d)
  );

  sram_lane_capture #(.LANES(LANES)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .capture ((st_q == ST_RACC) && expired),
    .mask    (mask_q),
    .dq_in   (mem_dq_in),
    .rdata   (rsp_rdata)
  );

  assign mem_ce_n   = pin_q.ce_n;
  assign mem_we_n   = pin_q.we_n;
  assign mem_oe_n   = pin_q.oe_n;
  assign mem_ub_n   = pin_q.ub_n;
  assign mem_lb_n   = pin_q.lb_n;
  assign mem_dq_oe  = pin_q.dq_oe;
  assign req_ready  = pin_q.ready;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_lane_ctl_chk.sv
module sram_lane_ctl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_ub_n,
  input logic              mem_lb_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  // R1: a deselected memory sees no strobe and an undriven bus
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

  // R2: lanes and address are stable through the strobe and into hold
  a_r2_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> (!mem_ce_n && $stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));

  // R2: the strobe never falls without a setup cycle before it
  a_r2_setup_before_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr)));

  // R3: a write strobe always has at least one lane selected
  a_r3_lane_on_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !(mem_ub_n && mem_lb_n));

  // R6: bus drive only under the write strobe
  a_r6_drive_in_write: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n);

  // R6: output enable excludes both write strobe and bus drive
  a_r6_no_clash: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  // R6: bus released the cycle before output enable falls
  a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R8: ready is a single-cycle pulse
  a_r8_ready_single: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);
endmodule

bind sram_lane_ctl sram_lane_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctl_test.sv
module sram_lane_ctl_test;
  localparam int ACC_NS = 45;
  localparam int CLK_NS = 20;
  localparam int AW     = 18;
  // R9: expected wait count, ceil(45/20) = 3
  localparam int W      = (ACC_NS + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_mask = '0;
  logic          req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0]   rsp_rdata, mem_dq_out, mem_dq_in, rd_word;
  logic [AW-1:0] mem_addr;
  logic          mem_drive;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] model_mem [int];
  logic [15:0] ref_mem   [int];

  sram_lane_ctl #(.ADDR_W(AW), .ACCESS_NS(ACC_NS), .CLK_NS(CLK_NS)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // behavioural memory: drives the pins only in a lane-enabled read
  assign mem_drive = !mem_ce_n && !mem_oe_n && mem_we_n && !(mem_ub_n && mem_lb_n);
  always_comb begin
    rd_word = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
    if (mem_drive)
      mem_dq_in = {mem_ub_n ? 8'h00 : rd_word[15:8], mem_lb_n ? 8'h00 : rd_word[7:0]};
    else if (mem_dq_oe)
      mem_dq_in = mem_dq_out;
    else
      mem_dq_in = 16'h0000;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [15:0] w;
      // R6: both sides must never drive the bus at once
      if (mem_drive && mem_dq_oe) check("R6 bus contention", 1, 0);
      if (!mem_ce_n && !mem_we_n) begin
        w = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
        if (!mem_lb_n) w[7:0]  = mem_dq_in[7:0];
        if (!mem_ub_n) w[15:8] = mem_dq_in[15:8];
        model_mem[int'(mem_addr)] = w;
      end
    end
  end

  function automatic logic [6:0] ctl_now();
    return {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready};
  endfunction

  task automatic txn(bit wr, logic [AW-1:0] a, logic [15:0] d, logic [1:0] m);
    int last;
    logic [6:0] e;
    logic [15:0] cur, exp_rd;
    logic ub, lb;
    string tag;
    last   = (m == 2'b00) ? 1 : W + 2;
    cur    = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    exp_rd = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
    if (wr) begin
      if (m[0]) cur[7:0]  = d[7:0];
      if (m[1]) cur[15:8] = d[15:8];
      ref_mem[int'(a)] = cur;
    end
    ub  = ~m[1];
    lb  = ~m[0];
    tag = (m == 2'b00) ? "R7 empty mask" : (wr ? "R2/R3 write" : "R4 read");
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    for (int n = 1; n <= last + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        // R8: fields change while busy and must be ignored
        req_addr = ~a; req_wdata = ~d; req_mask = ~m; req_write = ~wr;
      end
      if (n == last + 1)   e = 7'b1111100;
      else if (m == 2'b00) e = 7'b1111101;
      else if (wr) begin
        if (n == 1)           e = {3'b011, ub, lb, 2'b00};
        else if (n <= W + 1)  e = {3'b001, ub, lb, 2'b10};
        else                  e = {3'b011, ub, lb, 2'b01};
      end else begin
        if (n == 1)           e = {3'b011, ub, lb, 2'b00};
        else if (n <= W + 1)  e = {3'b010, ub, lb, 2'b00};
        else                  e = 7'b1111101;
      end
      check((n == last + 1) ? "R8 idle after ready" : tag, 32'(ctl_now()), 32'(e));
      if (!mem_ce_n) check("R10 address", 32'(mem_addr), 32'(a));
      if (mem_dq_oe) check("R2 write data", 32'(mem_dq_out), 32'(d));
      if (!wr && m != 2'b00 && n == last) check("R5 read data", 32'(rsp_rdata), 32'(exp_rd));
      if (n == last) req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pins", 32'(ctl_now()), 32'(7'b1111100));
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle pins", 32'(ctl_now()), 32'(7'b1111100));

    txn(1, 18'h00123, 16'hA55A, 2'b11);   // full word
    txn(0, 18'h00123, 16'h0000, 2'b11);
    txn(1, 18'h00123, 16'h3C77, 2'b01);   // R3 lower lane only
    txn(0, 18'h00123, 16'h0000, 2'b11);
    txn(1, 18'h00123, 16'hEE00, 2'b10);   // R3 upper lane only
    txn(0, 18'h00123, 16'h0000, 2'b11);
    txn(0, 18'h00123, 16'h0000, 2'b10);   // R5 lower lane masked off
    txn(0, 18'h00123, 16'h0000, 2'b01);   // R5 upper lane masked off
    txn(1, 18'h00123, 16'hFFFF, 2'b00);   // R7 empty write
    txn(0, 18'h00123, 16'h0000, 2'b11);   // R7 memory unchanged
    txn(0, 18'h00123, 16'h0000, 2'b00);   // R7 empty read
    txn(1, 18'h00000, 16'h1357, 2'b11);   // lowest address
    txn(1, 18'h3FFFF, 16'h9BDF, 2'b11);   // highest address
    txn(0, 18'h00000, 16'h0000, 2'b11);
    txn(0, 18'h3FFFF, 16'h0000, 2'b11);
    txn(0, 18'h2AAAA, 16'h0000, 2'b11);   // never written, reads zero

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule